// File: doc/BRIEF.md
# Single-Register Interrupt Gatherer

This block collects interrupt requests from up to fifteen sources and combines them into one interrupt line for a processor. Its whole state sits behind a single 32-bit word: one latched pending flag per source, one enable flag per source, and a master enable. A rising edge on a source request sets that source's pending flag. The flag then stays set until software acknowledges it.

Software never has to read the register before changing it. In every write, a zero bit leaves the matching state as it is. Each 1 in the low field acknowledges the matching pending flag. Each 1 in the enable field sets or clears the matching enable, and the top bit of the same word chooses which: a 1 there sets, a 0 clears. The top bit is also copied into the master enable on every write. Software can therefore, in one write, turn a source on, drop any old request from it and arm the master enable. Register writes are a plain strobe that is taken on every cycle it is high. There is no back-pressure and no valid/ready pair. The read word is always available.

Top module: `irq_gather_reg`

## Requirements
- R1: After a synchronous active-low reset, the read word is 0x00000000 and `irq_o` is low.
- R2: A rising edge on `src_req[k]` sets pending bit k (read bit k) at the clock edge where the high level is first sampled. A level that stays high does not set the bit again once it has been acknowledged.
- R3: A pending bit stays set until a write carries a 1 at bit k, and that write clears it. Zeros written in bits 14..0 leave the pending bits unchanged.
- R4: When a rising edge on source k and a write with a 1 at bit k land on the same clock edge, pending bit k ends set.
- R5: A write with bit 31 = 1 sets enable bit k (read bit 16+k) for every 1 written at bit 16+k. The other enable bits are unchanged.
- R6: A write with bit 31 = 0 clears enable bit k for every 1 written at bit 16+k. The other enable bits are unchanged.
- R7: Every write loads bit 31 of the written word into the master enable (read bit 31). With no write, the master enable holds its value.
- R8: Read bit 15 is 1 exactly when at least one pending bit is set, whatever the enables hold.
- R9: `irq_o` is high exactly when the master enable is set and some source is both enabled and pending. It follows the register state with no added cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr_en | input | 1 | Register write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write word |
| src_req | input | NUM_SRC | Interrupt requests, one per source, edge sensitive |
| bus_rd_data | output | 32 | Register read word |
| irq_o | output | 1 | Combined interrupt to the processor |

## Verification
All state can be seen in the read word one cycle after the write or edge that changed it. A wrong pending, enable or master flag therefore shows up at the next sample of `bus_rd_data`, and `irq_o` goes wrong in the same cycle. The directed cases cover these: acknowledges mixed with zeros, enable set and clear writes that must leave their neighbours alone, a request that is held high across an acknowledge, and an edge that collides with an acknowledge. Each case checks the full read word, so a stray bit change anywhere in the word is caught.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  localparam int REG_W       = 32;
  localparam int MAX_SRC     = 15;
  localparam int MASTER_POS  = 31;
  localparam int EN_BASE     = 16;
  localparam int SUMMARY_POS = 15;

  typedef struct packed {
    logic               valid;
    logic               master;
    logic [MAX_SRC-1:0] en_sel;
    logic [MAX_SRC-1:0] ack;
  } wr_cmd_t;

  function automatic wr_cmd_t decode_write(input logic wr, input logic [REG_W-1:0] w);
    wr_cmd_t c;
    c.valid  = wr;
    c.master = w[MASTER_POS];
    c.en_sel = w[EN_BASE +: MAX_SRC];
    c.ack    = w[MAX_SRC-1:0];
    return c;
  endfunction
endpackage

// File: rtl/irq_rise_detect.sv
module irq_rise_detect #(
  parameter int NUM_SRC = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  output logic [NUM_SRC-1:0] rise_o
);
  logic [NUM_SRC-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= req_i;
  end

  assign rise_o = req_i & ~prev_q;
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_SRC = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic               ack_en_i,
  input  logic [NUM_SRC-1:0] ack_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_pend
    logic pend_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                      pend_q <= 1'b0;
      else if (rise_i[k])              pend_q <= 1'b1;   // new edge outranks acknowledge
      else if (ack_en_i && ack_i[k])   pend_q <= 1'b0;
    end
    assign pend_o[k] = pend_q;
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int NUM_SRC = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic               master_i,
  input  logic [NUM_SRC-1:0] sel_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic               master_o
);
  logic master_q;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_en
    logic en_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                 en_q <= 1'b0;
      else if (wr_i && sel_i[k])  en_q <= master_i;
    end
    assign en_o[k] = en_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    master_q <= 1'b0;
    else if (wr_i) master_q <= master_i;
  end

  assign master_o = master_q;
endmodule

// File: rtl/irq_gather_reg.sv
module irq_gather_reg
  import irq_gather_pkg::*;
#(
  parameter int NUM_SRC = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr_en,
  input  logic [REG_W-1:0]   bus_wdata,
  input  logic [NUM_SRC-1:0] src_req,
  output logic [REG_W-1:0]   bus_rd_data,
  output logic               irq_o
);
  localparam int N = (NUM_SRC > MAX_SRC) ? MAX_SRC : NUM_SRC;

  wr_cmd_t        cmd;
  logic [N-1:0]   rise;
  logic [N-1:0]   pend;
  logic [N-1:0]   en;
  logic           master;
  logic           unused_wdata_bit;

  assign cmd              = decode_write(bus_wr_en, bus_wdata);
  assign unused_wdata_bit = bus_wdata[SUMMARY_POS];

  irq_rise_detect #(.NUM_SRC(N)) rise_i (
    .clk(clk), .rst_n(rst_n), .req_i(src_req[N-1:0]), .rise_o(rise)
  );

  irq_pend_bank #(.NUM_SRC(N)) pend_i (
    .clk(clk), .rst_n(rst_n), .rise_i(rise),
    .ack_en_i(cmd.valid), .ack_i(cmd.ack[N-1:0]), .pend_o(pend)
  );

  irq_mask_bank #(.NUM_SRC(N)) mask_i (
    .clk(clk), .rst_n(rst_n), .wr_i(cmd.valid), .master_i(cmd.master),
    .sel_i(cmd.en_sel[N-1:0]), .en_o(en), .master_o(master)
  );

  always_comb begin
    bus_rd_data                 = '0;
    bus_rd_data[N-1:0]          = pend;
    bus_rd_data[EN_BASE +: N]   = en;
    bus_rd_data[SUMMARY_POS]    = |pend;
    bus_rd_data[MASTER_POS]     = master;
  end

  assign irq_o = master & (|(pend & en));
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr_en,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rd_data,
  input logic        irq_o
);
  AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> bus_rd_data[31]); // R9

  AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(bus_rd_data[14:0] & bus_rd_data[30:16]))); // R9

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_en |=> (($past(bus_rd_data[14:0]) & ~bus_rd_data[14:0]) == 15'd0)); // R3

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_en |=> $stable(bus_rd_data[31:16])); // R7

  AST_MASTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en |=> bus_rd_data[31] == $past(bus_wdata[31])); // R7

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_wdata[31]) |=>
      ((bus_rd_data[30:16] & $past(bus_wdata[30:16])) == $past(bus_wdata[30:16]))); // R5

  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && !bus_wdata[31]) |=>
      ((bus_rd_data[30:16] & $past(bus_wdata[30:16])) == 15'd0)); // R6
endmodule

bind irq_gather_reg irq_gather_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
  .bus_rd_data(bus_rd_data), .irq_o(irq_o)
);

// File: tb/irq_gather_reg_tb_top.sv
`timescale 1ns/1ps
module irq_gather_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [14:0] src_req = '0;
  logic [31:0] bus_rd_data;
  logic        irq_o;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;   // 50 MHz

  irq_gather_reg #(.NUM_SRC(15)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
    .src_req(src_req), .bus_rd_data(bus_rd_data), .irq_o(irq_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [31:0] w);
    bus_wr_en = 1'b1;
    bus_wdata = w;
    tick();
    bus_wr_en = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic pulse(input int k);
    src_req[k] = 1'b1;
    tick();
    src_req[k] = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    check("R1 read word", bus_rd_data, 32'h0);
    check("R1 irq", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_edge_and_ack();
    src_req[3] = 1'b1;
    tick();
    check("R2 pend on edge", bus_rd_data, 32'h0000_8008);       // R8 summary set
    check("R9 no irq master off", {31'd0, irq_o}, 32'd0);
    reg_write(32'h0000_0000);
    check("R3 zeros keep pend", bus_rd_data, 32'h0000_8008);
    reg_write(32'h0000_0008);                                  // level still high
    check("R2 level no reset", bus_rd_data, 32'h0000_0000);
    check("R8 summary clear", {31'd0, bus_rd_data[15]}, 32'd0);
    src_req[3] = 1'b0;
    tick();
    check("R2 fall no effect", bus_rd_data, 32'h0);
  endtask

  task automatic t_single_source();
    reg_write(32'h8010_0010);
    check("R5 enable src4", bus_rd_data, 32'h8010_0000);
    pulse(4);
    check("R9 irq on", {31'd0, irq_o}, 32'd1);
    check("R2 pend src4", bus_rd_data, 32'h8010_8010);
    reg_write(32'h0000_0000);
    check("R7 master drop", bus_rd_data, 32'h0010_8010);
    check("R9 irq off master", {31'd0, irq_o}, 32'd0);
    reg_write(32'h8000_0000);
    check("R9 irq back", {31'd0, irq_o}, 32'd1);
    reg_write(32'h0010_0010);
    check("R6 disable and ack", bus_rd_data, 32'h0);
  endtask

  task automatic t_multi_and_collide();
    reg_write(32'h80FF_0000);
    check("R5 enable 0-7", bus_rd_data, 32'h80FF_0000);
    reg_write(32'h0005_0000);
    check("R6 clear 0 and 2 only", bus_rd_data, 32'h00FA_0000);
    reg_write(32'h8000_0000);
    check("R7 master only", bus_rd_data, 32'h80FA_0000);
    pulse(0);
    check("R9 disabled src no irq", {31'd0, irq_o}, 32'd0);
    check("R8 summary disabled src", bus_rd_data, 32'h80FA_8001);
    pulse(1);
    check("R9 enabled src irq", {31'd0, irq_o}, 32'd1);
    pulse(6);
    check("R2 pend 0,1,6", bus_rd_data, 32'h80FA_8043);
    src_req[6] = 1'b1;
    reg_write(32'h8000_0042);
    check("R4 edge beats ack", bus_rd_data, 32'h80FA_8041);
    src_req[6] = 1'b0;
    tick();
    reg_write(32'h8000_0041);
    check("R3 ack all", bus_rd_data, 32'h80FA_0000);
    check("R9 irq idle", {31'd0, irq_o}, 32'd0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_edge_and_ack();
    t_single_source();
    t_multi_and_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule